// File: doc/BRIEF.md
# Waveform Compare Timer Channel

A single timer channel that generates two digital waveforms from a free-running counter. The counter advances on each cycle in which the tick input is high and the channel's clock is switched on. Its value is compared against three programmable thresholds, A, B and C. Compare hits, an edge on a selectable external line and a software trigger each drive waveform outputs A and B. Every pairing of event and output carries its own 2-bit action: leave the level alone, drive it high, drive it low, or invert it. The counter offers four counting shapes. Compare C can also restart the count, turn it around, halt it or switch the channel off.

Software programs the channel through a plain write port with one address per register. Address 0 is a command register whose bits act only in the cycle they are written. Address 1 is the mode word. Addresses 2, 3 and 4 hold the A, B and C thresholds. Outputs: the counter value, the clock-on state, the two waveform levels, and a 5-bit flag vector that pulses for one cycle after a compare or overflow hit.

Top module: `wave_cmp_timer`

## Requirements
- R1: After reset the counter is 0, both waveform outputs are low, the clock is off and every flag is 0.
- R2: Command bit 0 switches the clock on and command bit 1 switches it off; when both are written together the clock ends up off. The counter moves only on a clock edge where tick_i is high and the clock is on.
- R3: In plain up mode (mode[1:0]=0) the counter goes from all-ones to 0, and flag bit 0 pulses in the cycle after that wrap.
- R4: In up mode with restart on C (mode[1:0]=2), the counter returns to 0 on the tick after it equals threshold C, and flag bit 4 pulses.
- R5: In up-down mode (mode[1:0]=1) the counter turns downward at all-ones and upward again at 0. Mode 3 turns downward at threshold C instead.
- R6: Flag bits 2, 3 and 4 pulse for one cycle after a tick on which the counter equals threshold A, B or C. Flag bit 1 is always 0.
- R7: Each action code acts on the next edge: 0 keeps the level, 1 sets it high, 2 clears it low, 3 inverts it. The fields are:
  - output A: compare A mode[10:9], compare C [12:11], external event [14:13], software trigger [16:15];
  - output B: compare B [18:17], compare C [20:19], external event [22:21], software trigger [24:23].
- R8: Among the events that reach an output in the same cycle with a nonzero action, the software trigger wins, then the external event, then compare C, then compare A or B. An event whose action is 0 never masks a lower one.
- R9: With mode bit 2 set, a compare C hit halts the counter while the clock stays on. With mode bit 3 set, a compare C hit switches the clock off.
- R10: Command bit 2 (software trigger) forces the counter to 0, counting upward. It also clears a halt caused by compare C.
- R11: The external event source is chosen by mode[7:6]: 0 = in_b_i, 1 to 3 = ext_clk_i[0] to [2]. The edge is chosen by mode[5:4]: 0 none, 1 rising, 2 falling, 3 both. With mode bit 8 set, the event also restarts the counter as in R10.
- R12: clk_on_o shows the clock state. out_a_o and out_b_o show the waveform levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0 command, 1 mode, 2 A, 3 B, 4 C) |
| wr_data_i | input | 25 | Write data |
| tick_i | input | 1 | Count enable from the selected time base |
| ext_clk_i | input | 3 | External lines usable as event source |
| in_b_i | input | 1 | Line B, usable as event source |
| cnt_o | output | CNT_W | Counter value |
| clk_on_o | output | 1 | Clock-on state |
| out_a_o | output | 1 | Waveform A |
| out_b_o | output | 1 | Waveform B |
| flag_o | output | 5 | One-cycle event flags (bit0 overflow, bits 2-4 compares) |

## Verification
The hardest case to reach is several events landing on one output in the same edge. Examples are a compare C hit on the same tick as a compare A hit, or an external edge arriving in the very cycle of a software trigger. The bench runs a narrow counter and aligns thresholds A and C, so both hits fall on one computed tick. It then asserts the external line in the same negedge at which it issues the trigger write. Full-period sweeps over every counting shape and every action code, from both starting levels, compare each cycle against arithmetic expectations.

// File: rtl/wct_pkg.sv
package wct_pkg;
   localparam int ADDR_W    = 3;
   localparam int N_EXT_CLK = 3;
   localparam int N_FLAG    = 5;

   localparam logic [ADDR_W-1:0] REG_CMD  = 3'd0;
   localparam logic [ADDR_W-1:0] REG_MODE = 3'd1;
   localparam logic [ADDR_W-1:0] REG_THA  = 3'd2;
   localparam logic [ADDR_W-1:0] REG_THB  = 3'd3;
   localparam logic [ADDR_W-1:0] REG_THC  = 3'd4;

   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_SET  = 2'd1,
      ACT_CLR  = 2'd2,
      ACT_TGL  = 2'd3
   } act_e;

   // mode word, MSB first
   typedef struct packed {
      act_e       b_sw;
      act_e       b_ext;
      act_e       b_c;
      act_e       b_cmp;
      act_e       a_sw;
      act_e       a_ext;
      act_e       a_c;
      act_e       a_cmp;
      logic       trg_en;
      logic [1:0] ev_src;
      logic [1:0] ev_edge;
      logic       dis_c;
      logic       stop_c;
      logic [1:0] shape;
   } mode_t;

   localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/wct_evt_sel.sv
module wct_evt_sel #(
   parameter int N_EXT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_b_i,
   input  logic [N_EXT-1:0] ext_i,
   input  logic [$clog2(N_EXT+1)-1:0] sel_i,
   input  logic [1:0] edge_i,
   output logic evt_o
);
   localparam int SEL_W = $clog2(N_EXT+1);

   if ((1 << SEL_W) != N_EXT + 1) begin : g_bad_cfg
      $error("wct_evt_sel: source count must fill the select field");
   end

   logic [N_EXT:0] srcs;
   logic           cur;
   logic           prev_q;

   assign srcs  = {ext_i, in_b_i};
   assign cur   = srcs[sel_i];
   assign evt_o = (edge_i[0] & cur & ~prev_q) | (edge_i[1] & ~cur & prev_q);

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= cur;
   end

   // an event is only ever seen on a level change of the chosen line
   p_evt_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |=> (prev_q != $past(prev_q)));
endmodule

// File: rtl/wct_counter.sv
module wct_counter #(
   parameter int CNT_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic trig_i,
   input  logic en_req_i,
   input  logic dis_req_i,
   input  logic [1:0] shape_i,
   input  logic stop_c_i,
   input  logic dis_c_i,
   input  logic [CNT_W-1:0] tha_i,
   input  logic [CNT_W-1:0] thb_i,
   input  logic [CNT_W-1:0] thc_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic clk_on_o,
   output logic hit_a_o,
   output logic hit_b_o,
   output logic hit_c_o,
   output logic ovf_o
);
   if (CNT_W < 2) begin : g_bad_w
      $error("wct_counter: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

   logic             up_q, up_d, halt_q, adv, auto_c, updn;
   logic [CNT_W-1:0] top, cnt_d;

   assign auto_c  = shape_i[1];
   assign updn    = shape_i[0];
   assign top     = auto_c ? thc_i : CNT_MAX;
   assign adv     = tick_i & clk_on_o & ~halt_q & ~trig_i;
   assign hit_a_o = adv & (cnt_o == tha_i);
   assign hit_b_o = adv & (cnt_o == thb_i);
   assign hit_c_o = adv & (cnt_o == thc_i);
   assign ovf_o   = adv & (cnt_o == CNT_MAX) & ~(auto_c & (cnt_o == thc_i));

   always_comb begin
      cnt_d = cnt_o;
      up_d  = up_q;
      if (trig_i) begin
         cnt_d = '0;
         up_d  = 1'b1;
      end else if (adv) begin
         if (!updn) begin
            cnt_d = (auto_c && cnt_o == thc_i) ? '0 : cnt_o + ONE;
            up_d  = 1'b1;
         end else if (up_q) begin
            if (cnt_o >= top) begin
               up_d  = 1'b0;
               cnt_d = (top == '0) ? '0 : top - ONE;
            end else begin
               cnt_d = cnt_o + ONE;
            end
         end else begin
            if (cnt_o == '0) begin
               up_d  = 1'b1;
               cnt_d = (top == '0) ? '0 : ONE;
            end else begin
               cnt_d = cnt_o - ONE;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_o    <= '0;
         up_q     <= 1'b1;
         halt_q   <= 1'b0;
         clk_on_o <= 1'b0;
      end else begin
         cnt_o <= cnt_d;
         up_q  <= up_d;
         if (trig_i)                     halt_q <= 1'b0;
         else if (hit_c_o && stop_c_i)   halt_q <= 1'b1;
         if (dis_req_i || (hit_c_o && dis_c_i)) clk_on_o <= 1'b0;
         else if (en_req_i)                     clk_on_o <= 1'b1;
      end
   end

   p_trig_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      trig_i |=> (cnt_o == '0));
   p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !trig_i) |=> $stable(cnt_o));
   p_off_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dis_req_i |=> !clk_on_o);
   p_auto_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_c_o && shape_i == 2'b10) |=> (cnt_o == '0));
endmodule

// File: rtl/wct_out_ctl.sv
module wct_out_ctl
   import wct_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ev_sw_i,
   input  logic ev_ext_i,
   input  logic ev_c_i,
   input  logic ev_cmp_i,
   input  act_e act_sw_i,
   input  act_e act_ext_i,
   input  act_e act_c_i,
   input  act_e act_cmp_i,
   output logic lvl_o
);
   act_e win;
   logic lvl_d;

   // later lines override earlier: lowest priority first
   always_comb begin
      win = ACT_NONE;
      if (ev_cmp_i && act_cmp_i != ACT_NONE) win = act_cmp_i;
      if (ev_c_i   && act_c_i   != ACT_NONE) win = act_c_i;
      if (ev_ext_i && act_ext_i != ACT_NONE) win = act_ext_i;
      if (ev_sw_i  && act_sw_i  != ACT_NONE) win = act_sw_i;
      case (win)
         ACT_SET: lvl_d = 1'b1;
         ACT_CLR: lvl_d = 1'b0;
         ACT_TGL: lvl_d = ~lvl_o;
         default: lvl_d = lvl_o;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_o <= 1'b0;
      else        lvl_o <= lvl_d;
   end

   p_sw_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_sw_i && act_sw_i == ACT_SET) |=> lvl_o);
   p_sw_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_sw_i && act_sw_i == ACT_CLR) |=> !lvl_o);
   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_sw_i && !ev_ext_i && !ev_c_i && !ev_cmp_i) |=> $stable(lvl_o));
endmodule

// File: rtl/wave_cmp_timer.sv
module wave_cmp_timer
   import wct_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [MODE_W-1:0] wr_data_i,
   input  logic tick_i,
   input  logic [N_EXT_CLK-1:0] ext_clk_i,
   input  logic in_b_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic clk_on_o,
   output logic out_a_o,
   output logic out_b_o,
   output logic [N_FLAG-1:0] flag_o
);
   if (CNT_W < 2 || CNT_W > MODE_W) begin : g_bad_w
      $error("wave_cmp_timer: CNT_W out of range for the write port");
   end

   mode_t            mode_q;
   logic [CNT_W-1:0] tha_q, thb_q, thc_q;
   logic             cmd_wr, en_req, dis_req, sw_trig, ext_evt, trig;
   logic             hit_a, hit_b, hit_c, ovf;
   logic [3:0]       fl_q;
   logic [1:0]       lvl, hit_cmp;
   act_e             act_sw [2];
   act_e             act_ext[2];
   act_e             act_c  [2];
   act_e             act_cmp[2];

   assign cmd_wr  = wr_en_i && (wr_addr_i == REG_CMD);
   assign en_req  = cmd_wr & wr_data_i[0];
   assign dis_req = cmd_wr & wr_data_i[1];
   assign sw_trig = cmd_wr & wr_data_i[2];
   assign trig    = sw_trig | (ext_evt & mode_q.trg_en);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         tha_q  <= '0;
         thb_q  <= '0;
         thc_q  <= '0;
         fl_q   <= '0;
      end else begin
         fl_q <= {hit_c, hit_b, hit_a, ovf};
         if (wr_en_i) begin
            case (wr_addr_i)
               REG_MODE: mode_q <= mode_t'(wr_data_i);
               REG_THA:  tha_q  <= wr_data_i[CNT_W-1:0];
               REG_THB:  thb_q  <= wr_data_i[CNT_W-1:0];
               REG_THC:  thc_q  <= wr_data_i[CNT_W-1:0];
               default: ;
            endcase
         end
      end
   end

   wct_evt_sel #(.N_EXT(N_EXT_CLK)) u_evt (
      .clk(clk), .rst_n(rst_n), .in_b_i(in_b_i), .ext_i(ext_clk_i),
      .sel_i(mode_q.ev_src), .edge_i(mode_q.ev_edge), .evt_o(ext_evt)
   );

   wct_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .trig_i(trig),
      .en_req_i(en_req), .dis_req_i(dis_req), .shape_i(mode_q.shape),
      .stop_c_i(mode_q.stop_c), .dis_c_i(mode_q.dis_c),
      .tha_i(tha_q), .thb_i(thb_q), .thc_i(thc_q), .cnt_o(cnt_o),
      .clk_on_o(clk_on_o), .hit_a_o(hit_a), .hit_b_o(hit_b),
      .hit_c_o(hit_c), .ovf_o(ovf)
   );

   assign act_sw[0]  = mode_q.a_sw;   assign act_sw[1]  = mode_q.b_sw;
   assign act_ext[0] = mode_q.a_ext;  assign act_ext[1] = mode_q.b_ext;
   assign act_c[0]   = mode_q.a_c;    assign act_c[1]   = mode_q.b_c;
   assign act_cmp[0] = mode_q.a_cmp;  assign act_cmp[1] = mode_q.b_cmp;
   assign hit_cmp    = {hit_b, hit_a};

   for (genvar g = 0; g < 2; g++) begin : g_wave
      wct_out_ctl u_oc (
         .clk(clk), .rst_n(rst_n), .ev_sw_i(sw_trig), .ev_ext_i(ext_evt),
         .ev_c_i(hit_c), .ev_cmp_i(hit_cmp[g]), .act_sw_i(act_sw[g]),
         .act_ext_i(act_ext[g]), .act_c_i(act_c[g]),
         .act_cmp_i(act_cmp[g]), .lvl_o(lvl[g])
      );
   end

   assign out_a_o = lvl[0];
   assign out_b_o = lvl[1];
   assign flag_o  = {fl_q[3:1], 1'b0, fl_q[0]};

   p_on_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_req && !dis_req && !(hit_c && mode_q.dis_c)) |=> clk_on_o);
   p_flag_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i) |=> (flag_o == '0));
endmodule

// File: tb/wave_cmp_timer_tb.sv
module wave_cmp_timer_tb;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_addr = '0;
   logic [24:0]  wr_data = '0;
   logic         tick = 1'b0;
   logic [2:0]   ext_clk = '0;
   logic         in_b = 1'b0;
   logic [W-1:0] cnt;
   logic         clk_on, out_a, out_b;
   logic [4:0]   flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   wave_cmp_timer #(.CNT_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .tick_i(tick), .ext_clk_i(ext_clk), .in_b_i(in_b),
      .cnt_o(cnt), .clk_on_o(clk_on), .out_a_o(out_a), .out_b_o(out_b),
      .flag_o(flag)
   );

   task automatic step(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input int unsigned d);
      wr_en   = 1'b1;
      wr_addr = a[2:0];
      wr_data = d[24:0];
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int apply(input int code, input int lvl);
      case (code)
         1: return 1;
         2: return 0;
         3: return 1 - lvl;
         default: return lvl;
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int c0;
      step(3);
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 cnt", int'(cnt), 0);
      chk("R1 out_a", int'(out_a), 0);
      chk("R1 out_b", int'(out_b), 0);
      chk("R1 clk_on", int'(clk_on), 0);
      chk("R1 flags", int'(flag), 0);

      // R3 / R6: plain up sweep with compare flags
      tick = 1'b1;
      wr(2, 10); wr(3, 20); wr(4, 200); wr(1, 0);
      chk("R2 idle while off", int'(cnt), 0);
      wr(0, 1);
      chk("R12 clk_on mirror", int'(clk_on), 1);
      for (int i = 1; i <= 300; i++) begin
         step();
         chk("R3 up count", int'(cnt), i % 256);
         chk("R3 overflow flag", int'(flag[0]), (i % 256 == 0) ? 1 : 0);
         chk("R6 flag A", int'(flag[2]), ((i + 255) % 256 == 10) ? 1 : 0);
         chk("R6 flag B", int'(flag[3]), ((i + 255) % 256 == 20) ? 1 : 0);
         chk("R6 flag C", int'(flag[4]), ((i + 255) % 256 == 200) ? 1 : 0);
         chk("R6 flag bit1", int'(flag[1]), 0);
      end

      // R2: on and off together leaves the clock off
      wr(0, 3);
      chk("R2 off wins", int'(clk_on), 0);
      c0 = int'(cnt);
      step(5);
      chk("R2 frozen when off", int'(cnt), c0);
      // R2: tick gating
      wr(0, 1);
      tick = 1'b0;
      c0 = int'(cnt);
      step(5);
      chk("R2 frozen without tick", int'(cnt), c0);
      tick = 1'b1;
      step();
      chk("R2 resumes with tick", int'(cnt), (c0 + 1) % 256);

      // R10 software trigger
      wr(0, 4);
      chk("R10 trigger zero", int'(cnt), 0);
      step();
      chk("R10 restart", int'(cnt), 1);

      // R4 up with restart on C
      wr(4, 50); wr(1, 2); wr(0, 5);
      for (int i = 1; i <= 120; i++) begin
         step();
         chk("R4 auto count", int'(cnt), i % 51);
         chk("R4 flag C", int'(flag[4]), (i % 51 == 0) ? 1 : 0);
      end

      // R5 up-down full range
      wr(1, 1); wr(0, 5);
      for (int i = 1; i <= 600; i++) begin
         int p;
         p = i % 510;
         step();
         chk("R5 updown full", int'(cnt), (p <= 255) ? p : 510 - p);
      end
      // R5 up-down turning at C
      wr(4, 40); wr(1, 3); wr(0, 5);
      for (int i = 1; i <= 200; i++) begin
         int p;
         p = i % 80;
         step();
         chk("R5 updown at C", int'(cnt), (p <= 40) ? p : 80 - p);
      end

      // R9 halt on C, clock stays on
      wr(4, 30); wr(1, 4); wr(0, 5);
      step(40);
      chk("R9 halted value", int'(cnt), 31);
      chk("R9 halt keeps clock", int'(clk_on), 1);
      wr(0, 4);
      chk("R10 trigger from halt", int'(cnt), 0);
      step();
      chk("R10 halt cleared", int'(cnt), 1);
      // R9 switch off on C
      wr(1, 8); wr(0, 5);
      step(40);
      chk("R9 off value", int'(cnt), 31);
      chk("R9 clock off", int'(clk_on), 0);

      // R7 action code sweep on both outputs
      wr(2, 3); wr(3, 3); wr(4, 200);
      for (int ch = 0; ch < 2; ch++) begin
         for (int code = 0; code < 4; code++) begin
            for (int init = 0; init < 2; init++) begin
               int unsigned m;
               int sw;
               sw = (init != 0) ? 1 : 2;
               m = (ch == 0) ? ((code << 9) | (sw << 15))
                             : ((code << 17) | (sw << 23));
               wr(1, m);
               wr(0, 5);
               chk("R7 preset level", (ch == 0) ? int'(out_a) : int'(out_b), init);
               step(3);
               chk("R7 before hit", (ch == 0) ? int'(out_a) : int'(out_b), init);
               step();
               chk("R7 action result", (ch == 0) ? int'(out_a) : int'(out_b),
                   apply(code, init));
            end
         end
      end

      // R8 compare C beats compare A
      wr(2, 4); wr(4, 4);
      wr(1, 32'h200 | 32'h1000 | 32'h8000);
      wr(0, 5);
      chk("R8 preset high", int'(out_a), 1);
      step(5);
      chk("R8 C over A", int'(out_a), 0);
      // R8 a none action does not mask compare A
      wr(1, 32'h200 | 32'h10000);
      wr(0, 5);
      chk("R8 preset low", int'(out_a), 0);
      step(5);
      chk("R8 none does not mask", int'(out_a), 1);

      // R11 rising on in_b, then R8 trigger beats external event
      wr(1, 32'h2000 | 32'h10000 | 32'h10);
      wr(0, 4);
      chk("R8 cleared by trigger", int'(out_a), 0);
      in_b = 1'b1;
      step();
      chk("R11 rising sets", int'(out_a), 1);
      in_b = 1'b0;
      step();
      chk("R11 falling ignored", int'(out_a), 1);
      in_b = 1'b1;
      wr(0, 4);
      chk("R8 trigger over ext", int'(out_a), 0);
      in_b = 1'b0;
      step();

      // R11 source ext_clk[1], falling edge, toggle
      wr(1, 32'h160A0);
      wr(0, 4);
      chk("R11 preset low", int'(out_a), 0);
      ext_clk[1] = 1'b1;
      step();
      chk("R11 rising ignored", int'(out_a), 0);
      ext_clk[1] = 1'b0;
      step();
      chk("R11 falling toggles", int'(out_a), 1);
      in_b = 1'b1;
      step();
      in_b = 1'b0;
      step();
      ext_clk[0] = 1'b1;
      step();
      ext_clk[0] = 1'b0;
      step();
      chk("R11 other lines ignored", int'(out_a), 1);
      wr(1, 32'h160B0);
      ext_clk[1] = 1'b1;
      step();
      chk("R11 both rising", int'(out_a), 0);
      ext_clk[1] = 1'b0;
      step();
      chk("R11 both falling", int'(out_a), 1);

      // R11 external event as trigger
      wr(1, 32'h160B0 | 32'h100);
      wr(0, 1);
      step(10);
      chk("R11 counting before", (int'(cnt) > 0) ? 1 : 0, 1);
      ext_clk[1] = 1'b1;
      step();
      chk("R11 event restarts", int'(cnt), 0);
      step();
      chk("R11 counts after restart", int'(cnt), 1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule